// File: doc/BRIEF.md
# Mixed-Sign Byte Matrix Multiply-Accumulate Unit

This unit takes three 128-bit vectors on each accepted operation: a packed 2x2 matrix of signed 32-bit accumulators, a first source holding a 2x8 matrix of unsigned bytes, and a second source holding an 8x2 matrix of signed bytes. It multiplies the two byte matrices and adds the 2x2 product into the accumulators. The updated accumulator vector is returned in the same 128-bit layout, so a caller can feed it straight back in. Each output lane is the old lane plus an 8-term dot product. Every term pairs a zero-extended byte with a sign-extended byte.

The unit is a two-stage pipeline. The multipliers and the pairwise reduction trees sit in the first stage and the accumulate adders in the second. It accepts one operation per cycle and presents the result with a valid strobe a fixed two cycles later. No flags or overflow status are produced.

Top module: `mixed_mma`

## Requirements
- R1: Bytes of the first source are treated as unsigned (zero-extended), so a first source of all 0xFF against a second source of all 0x01 adds 2040 to every lane.
- R2: Bytes of the second source are treated as signed (sign-extended), so a first source of all 0x01 against a second source of all 0xFF adds -8 to every lane.
- R3: Result lane L = 2*i + j occupies bits [32*L+31:32*L]. It equals accumulator lane L plus the sum over k = 0..7 of first-source byte (8*i + k) times second-source byte (8*j + k). Byte n of either source sits at bits [8*n+7:8*n].
- R4: With all first-source bytes 0xFF and all second-source bytes 0x80, every lane gains exactly -261120, with no intermediate overflow.
- R5: With all first-source bytes 0xFF and all second-source bytes 0x7F, every lane gains exactly 259080.
- R6: The accumulate add wraps modulo 2^32 with no saturation. For example, 0x7FFFFFFF + 2040 gives 0x800007F7.
- R7: An operation is accepted in a cycle where inValid and inReady are both high. Its result appears on accOut with outValid high exactly two clock edges later, and outValid is low in every other cycle. inReady is high in every cycle after reset is released.
- R8: Operations accepted on consecutive cycles each produce their own result on consecutive cycles, in order.
- R9: While reset is asserted, outValid, inReady and accOut are all 0. Between results, accOut holds the last result.
- R10: An accepted operation whose first source or second source is all zero returns the accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operand bundle is valid |
| inReady | output | 1 | Unit can accept an operand bundle |
| accIn | input | 128 | Packed 2x2 int32 accumulator |
| srcA | input | 128 | 2x8 unsigned byte matrix, row-major |
| srcB | input | 128 | 8x2 signed byte matrix, stored as two 8-byte columns |
| outValid | output | 1 | accOut carries a new result |
| accOut | output | 128 | Updated packed 2x2 int32 accumulator |

## Verification
Each operation driven before a clock edge is captured at that edge. Its result and outValid are due after the second edge that follows. The bench carries a two-deep model pipeline of expected valid bits and expected results, advanced once per cycle. Every cycle it compares outValid, and then either the result or the held previous value, at the falling edge, half a period away from any capture edge. Directed extremes (all-0xFF unsigned rows against 0x80 or 0x7F columns, accumulators next to the int32 limits) run alongside back-to-back random operations and idle gaps.

// File: rtl/mixed_mma_pkg.sv
package mixed_mma_pkg;
  localparam int DEF_ROWS   = 2;
  localparam int DEF_COLS   = 2;
  localparam int DEF_DEPTH  = 8;
  localparam int DEF_EW     = 8;
  localparam int DEF_LANE_W = 32;

  typedef struct packed {
    logic s1Load;  // capture products and accumulator into stage 1
    logic s2Load;  // update the result register from stage 1
  } mma_strobe_t;
endpackage

// File: rtl/mma_ctrl.sv
module mma_ctrl
  import mixed_mma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  output logic        inReady,
  output logic        outValid,
  output mma_strobe_t strobe
);
  logic readyReg;
  logic v1;
  logic v2;
  logic accept;

  assign accept  = inValid && readyReg;
  assign inReady = readyReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      readyReg <= 1'b0;
      v1       <= 1'b0;
      v2       <= 1'b0;
    end else begin
      readyReg <= 1'b1;
      v1       <= accept;
      v2       <= v1;
    end
  end

  always_comb begin
    strobe.s1Load = accept;
    strobe.s2Load = v1;
  end

  assign outValid = v2;
endmodule

// File: rtl/mma_datapath.sv
module mma_datapath
  import mixed_mma_pkg::*;
#(
  parameter int ROWS   = DEF_ROWS,
  parameter int COLS   = DEF_COLS,
  parameter int DEPTH  = DEF_DEPTH,
  parameter int EW     = DEF_EW,
  parameter int LANE_W = DEF_LANE_W,
  localparam int A_W   = ROWS * DEPTH * EW,
  localparam int B_W   = COLS * DEPTH * EW,
  localparam int ACC_W = ROWS * COLS * LANE_W
)(
  input  logic             clk,
  input  logic             rst_n,
  input  mma_strobe_t      strobe,
  input  logic [ACC_W-1:0] accIn,
  input  logic [A_W-1:0]   srcA,
  input  logic [B_W-1:0]   srcB,
  output logic [ACC_W-1:0] accOut
);
  localparam int LANES  = ROWS * COLS;
  localparam int PROD_W = 2 * EW + 1;
  localparam int DOT_W  = PROD_W + $clog2(DEPTH);
  localparam int NODES  = 2 * DEPTH - 1;

  logic signed [DOT_W-1:0] dotNext [LANES];
  logic signed [DOT_W-1:0] dotReg  [LANES];
  logic [ACC_W-1:0]        accReg;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int RI = l / COLS;
    localparam int CJ = l % COLS;
    logic signed [DOT_W-1:0] node [NODES];

    for (genvar k = 0; k < DEPTH; k++) begin : g_term
      logic [EW-1:0]            aByte;
      logic [EW-1:0]            bByte;
      logic signed [PROD_W-1:0] aExt;
      logic signed [PROD_W-1:0] bExt;
      logic signed [PROD_W-1:0] prod;
      assign aByte = srcA[(RI*DEPTH + k)*EW +: EW];
      assign bByte = srcB[(CJ*DEPTH + k)*EW +: EW];
      assign aExt  = {{(PROD_W-EW){1'b0}}, aByte};
      assign bExt  = {{(PROD_W-EW){bByte[EW-1]}}, bByte};
      assign prod  = aExt * bExt;
      assign node[DEPTH-1+k] = {{(DOT_W-PROD_W){prod[PROD_W-1]}}, prod};
    end

    for (genvar n = 0; n < DEPTH - 1; n++) begin : g_tree
      assign node[n] = node[2*n+1] + node[2*n+2];
    end

    assign dotNext[l] = node[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accReg <= '0;
      accOut <= '0;
      for (int l = 0; l < LANES; l++) dotReg[l] <= '0;
    end else begin
      if (strobe.s1Load) begin
        accReg <= accIn;
        for (int l = 0; l < LANES; l++) dotReg[l] <= dotNext[l];
      end
      if (strobe.s2Load) begin
        for (int l = 0; l < LANES; l++)
          accOut[l*LANE_W +: LANE_W] <= accReg[l*LANE_W +: LANE_W]
            + {{(LANE_W-DOT_W){dotReg[l][DOT_W-1]}}, dotReg[l]};
      end
    end
  end
endmodule

// File: rtl/mixed_mma.sv
module mixed_mma
  import mixed_mma_pkg::*;
#(
  parameter int ROWS   = DEF_ROWS,
  parameter int COLS   = DEF_COLS,
  parameter int DEPTH  = DEF_DEPTH,
  parameter int EW     = DEF_EW,
  parameter int LANE_W = DEF_LANE_W,
  localparam int A_W   = ROWS * DEPTH * EW,
  localparam int B_W   = COLS * DEPTH * EW,
  localparam int ACC_W = ROWS * COLS * LANE_W
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inValid,
  output logic             inReady,
  input  logic [ACC_W-1:0] accIn,
  input  logic [A_W-1:0]   srcA,
  input  logic [B_W-1:0]   srcB,
  output logic             outValid,
  output logic [ACC_W-1:0] accOut
);
  mma_strobe_t strobe;

  mma_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .inReady  (inReady),
    .outValid (outValid),
    .strobe   (strobe)
  );

  mma_datapath #(
    .ROWS(ROWS), .COLS(COLS), .DEPTH(DEPTH), .EW(EW), .LANE_W(LANE_W)
  ) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .accIn  (accIn),
    .srcA   (srcA),
    .srcB   (srcB),
    .accOut (accOut)
  );
endmodule

// File: rtl/mixed_mma_checker.sv
module mixed_mma_checker #(
  parameter int A_W   = 128,
  parameter int B_W   = 128,
  parameter int ACC_W = 128
)(
  input logic             clk,
  input logic             rst_n,
  input logic             inValid,
  input logic             inReady,
  input logic [ACC_W-1:0] accIn,
  input logic [A_W-1:0]   srcA,
  input logic [B_W-1:0]   srcB,
  input logic             outValid,
  input logic [ACC_W-1:0] accOut
);
  AST_RESULT_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inReady) |-> ##2 outValid);  // R7
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !(inValid && inReady) |-> ##2 !outValid);  // R7
  AST_READY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    inReady |=> inReady);  // R7
  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !outValid |-> $stable(accOut));  // R9
  AST_ZERO_A: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inReady && srcA == '0) |-> ##2 (accOut == $past(accIn, 2)));  // R10
  AST_ZERO_B: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inReady && srcB == '0) |-> ##2 (accOut == $past(accIn, 2)));  // R10
endmodule

bind mixed_mma mixed_mma_checker #(.A_W(A_W), .B_W(B_W), .ACC_W(ACC_W)) u_chk (.*);

// File: tb/mixed_mma_test.sv
module mixed_mma_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         inValid = 1'b0;
  logic         inReady;
  logic [127:0] accIn = '0;
  logic [127:0] srcA = '0;
  logic [127:0] srcB = '0;
  logic         outValid;
  logic [127:0] accOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic         pV1 = 1'b0, pV2 = 1'b0;
  logic [127:0] pD1 = '0, pD2 = '0;
  logic [127:0] lastOut = '0;
  string        pT1 = "R3", pT2 = "R3";

  always #10 clk = ~clk;

  mixed_mma uut (.*);

  function automatic logic [127:0] model(logic [127:0] acc, logic [127:0] a, logic [127:0] b);
    logic [127:0] r;
    for (int l = 0; l < 4; l++) begin
      int i = l / 2;
      int j = l % 2;
      int sum = 0;
      for (int k = 0; k < 8; k++) begin
        int av = int'(a[(i*8+k)*8 +: 8]);
        int bv = int'($signed(b[(j*8+k)*8 +: 8]));
        sum += av * bv;
      end
      r[l*32 +: 32] = acc[l*32 +: 32] + 32'(sum);
    end
    return r;
  endfunction

  function automatic logic [127:0] splat(logic [7:0] v);
    return {16{v}};
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // One cycle: compare what is due now, advance the model pipeline, drive the next inputs.
  task automatic step(bit v, logic [127:0] acc, logic [127:0] a, logic [127:0] b, string tag);
    @(negedge clk);
    check("R7", 128'(outValid), 128'(pV2));
    if (pV2) begin
      check(pT2, accOut, pD2);
      lastOut = pD2;
    end else begin
      check("R9", accOut, lastOut);
    end
    check("R7", 128'(inReady), 128'(1));
    pV2 = pV1; pD2 = pD1; pT2 = pT1;
    pV1 = v;   pD1 = model(acc, a, b); pT1 = tag;
    inValid = v; accIn = acc; srcA = a; srcB = b;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [127:0] x;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R9", 128'(outValid), 128'(0));
    check("R9", 128'(inReady), 128'(0));
    check("R9", accOut, '0);
    rst_n = 1'b1;
    @(negedge clk);

    step(1, '0, splat(8'hFF), splat(8'h01), "R1");
    step(1, 128'd5, splat(8'h01), splat(8'hFF), "R2");
    step(1, '0, splat(8'hFF), splat(8'h80), "R4");
    step(1, '0, splat(8'hFF), splat(8'h7F), "R5");
    step(1, {4{32'h7FFFFFFF}}, splat(8'hFF), splat(8'h01), "R6");
    step(1, {4{32'h80000000}}, splat(8'hFF), splat(8'h80), "R6");
    step(0, '0, '0, '0, "R9");
    step(0, '0, '0, '0, "R9");
    x = rnd128();
    step(1, x, '0, rnd128(), "R10");
    step(1, x, rnd128(), '0, "R10");
    // single nonzero byte pairs probe the lane and byte mapping
    for (int l = 0; l < 4; l++) begin
      logic [127:0] a = '0;
      logic [127:0] b = '0;
      a[((l/2)*8 + 3)*8 +: 8] = 8'd200;
      b[((l%2)*8 + 3)*8 +: 8] = 8'hF6;
      step(1, 128'h0000_0004_0000_0003_0000_0002_0000_0001, a, b, "R3");
    end
    for (int n = 0; n < 300; n++) begin
      bit v = ($urandom % 4) != 0;
      step(v, rnd128(), rnd128(), rnd128(), (n < 40) ? "R8" : "R3");
    end
    for (int n = 0; n < 4; n++) step(0, '0, '0, '0, "R9");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule